// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner gathers 256 level-sensitive interrupt sources, organised as 32 groups of 8, and reduces each group to one output line. Every source has its own enable bit. Software turns enables on through a write-one-to-set location and off through a write-one-to-clear location. It can read the raw input levels, the masked levels, and a summary word that holds one pending flag per group.

Access goes through a plain synchronous register port with byte address, write strobe, write data and combinational read data. Four groups share each 32-bit word: group g sits in word g/4 at bits (g mod 4)*8 to (g mod 4)*8+7. Word n takes a 16-byte block at byte offset 0x10*n. Within that block, +0x0 is enable-set, +0x4 is enable-clear, +0x8 is raw status and +0xC is masked status. The summary word sits at 0x100. Inputs are taken as already synchronous levels. The block does no edge detection, no prioritising and no vectoring.

Top module: `grp_irq_combiner`

## Requirements
- R1: While reset is asserted, and after it is released, every enable bit is 0 and every `irq_o` bit is 0, whatever the source levels are.
- R2: A write to offset 0x10*n+0x0 sets every enable bit of word n whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to offset 0x10*n+0x4 clears every enable bit of word n whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A read of either 0x10*n+0x0 or 0x10*n+0x4 returns the current enable word n.
- R5: A read of 0x10*n+0x8 returns the current source levels `src_i[32n+31:32n]`.
- R6: A read of 0x10*n+0xC returns the raw word ANDed with enable word n.
- R7: `irq_o[g]` is a register. One clock edge after the masked bits of group g change, it equals the OR of those 8 bits.
- R8: A read of 0x100 returns a word whose bit g is the OR of group g's masked bits, as of the current cycle.
- R9: An address is mapped only if bits [1:0] are 0 and it is either 0x100 or lies below 0x80. A read of any other address returns 0, and a write to it changes no enable.
- R10: Writes to the raw-status, masked-status and summary offsets change no enable and no status.
- R11: Source s = 8g+b belongs to group g. It appears in word g/4 at bit (g mod 4)*8+b, drives `irq_o[g]`, and sets summary bit g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| src_i | input | 256 | Interrupt source levels, bit 8g+b is source b of group g |
| irq_o | output | 32 | Registered per-group interrupt lines |

## Verification
The bench walks set and clear writes that overlap, so that a set which overwrote instead of ORing, or a clear that inverted the sense, leaves a wrong enable word on readback. It times the output one edge after a source change and again after an enable change. An unregistered or doubly registered output is caught in the wrong cycle. Writes to the status, summary, unaligned and out-of-range addresses are each followed by readback of the enables and status they could have corrupted. Sources in groups 1, 5, 16 and 31 check that the word and bit placement lines up with both `irq_o` and the summary, which a shifted or mis-indexed group mapping would break.

// File: rtl/grp_irq_pkg.sv
`timescale 1ns/1ps
package grp_irq_pkg;
  // register kind selected by byte address bits [3:2] inside a 16-byte block
  typedef enum logic [1:0] {
    REG_EN_SET = 2'd0,
    REG_EN_CLR = 2'd1,
    REG_RAW    = 2'd2,
    REG_MASKED = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/grp_irq_decode.sv
`timescale 1ns/1ps
module grp_irq_decode
  import grp_irq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_WORDS   = 8,
  parameter int SUMMARY_OFF = 'h100,
  localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BLK_W      = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  output logic                 word_hit_o,
  output logic                 sum_hit_o,
  output reg_kind_e            kind_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [NUM_WORDS-1:0] set_sel_o,
  output logic [NUM_WORDS-1:0] clr_sel_o
);
  logic [BLK_W-1:0] blk;
  logic             aligned;

  assign blk        = addr_i[ADDR_W-1:4];
  assign aligned    = (addr_i[1:0] == 2'b00);
  assign word_hit_o = aligned && (int'(blk) < NUM_WORDS);
  assign sum_hit_o  = (addr_i == ADDR_W'(SUMMARY_OFF));
  assign kind_o     = reg_kind_e'(addr_i[3:2]);
  assign idx_o      = blk[IDX_W-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
    assign set_sel_o[w] = we_i && word_hit_o && (kind_o == REG_EN_SET) && (idx_o == IDX_W'(w));
    assign clr_sel_o[w] = we_i && word_hit_o && (kind_o == REG_EN_CLR) && (idx_o == IDX_W'(w));
  end

  always_comb begin
    // R9
    onehot_sel_chk: assert ($onehot0({set_sel_o, clr_sel_o}));
  end
endmodule

// File: rtl/grp_irq_enable_bank.sv
`timescale 1ns/1ps
module grp_irq_enable_bank #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32,
  localparam int TOTAL_W  = NUM_WORDS * DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WORDS-1:0] set_sel_i,
  input  logic [NUM_WORDS-1:0] clr_sel_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [TOTAL_W-1:0]   en_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           word_q <= '0;
      else if (set_sel_i[w]) word_q <= word_q | wdata_i;
      else if (clr_sel_i[w]) word_q <= word_q & ~wdata_i;
    end

    assign en_o[w*DATA_W +: DATA_W] = word_q;

    // R2
    en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_sel_i[w] |=> ((en_o[w*DATA_W +: DATA_W] & $past(wdata_i)) == $past(wdata_i)));
    // R3
    en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_sel_i[w] |=> ((en_o[w*DATA_W +: DATA_W] & $past(wdata_i)) == '0));
    // R10
    en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(set_sel_i[w] || clr_sel_i[w]) |=> $stable(en_o[w*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/grp_irq_reduce.sv
`timescale 1ns/1ps
module grp_irq_reduce #(
  parameter int NUM_GRP = 32,
  parameter int GRP_W   = 8,
  localparam int SRC_W  = NUM_GRP * GRP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [SRC_W-1:0]   en_i,
  output logic [SRC_W-1:0]   masked_o,
  output logic [NUM_GRP-1:0] pend_o,
  output logic [NUM_GRP-1:0] irq_o
);
  assign masked_o = src_i & en_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign pend_o[g] = |masked_o[g*GRP_W +: GRP_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[g] <= 1'b0;
      else         irq_o[g] <= pend_o[g];
    end

    // R7
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(src_i[g*GRP_W +: GRP_W] & en_i[g*GRP_W +: GRP_W])) |=> irq_o[g]);
    // R7
    irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[g*GRP_W +: GRP_W] == '0) |=> !irq_o[g]);
  end
endmodule

// File: rtl/grp_irq_read_mux.sv
`timescale 1ns/1ps
module grp_irq_read_mux
  import grp_irq_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_GRP   = 32,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int TOTAL_W  = NUM_WORDS * DATA_W
) (
  input  logic               word_hit_i,
  input  logic               sum_hit_i,
  input  reg_kind_e          kind_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [TOTAL_W-1:0] en_i,
  input  logic [TOTAL_W-1:0] src_i,
  input  logic [TOTAL_W-1:0] masked_i,
  input  logic [NUM_GRP-1:0] pend_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] en_word, src_word, msk_word;

  assign en_word  = en_i[idx_i*DATA_W +: DATA_W];
  assign src_word = src_i[idx_i*DATA_W +: DATA_W];
  assign msk_word = masked_i[idx_i*DATA_W +: DATA_W];

  always_comb begin
    rdata_o = '0;
    if (sum_hit_i) begin
      rdata_o = DATA_W'(pend_i);
    end else if (word_hit_i) begin
      unique case (kind_i)
        REG_EN_SET, REG_EN_CLR: rdata_o = en_word;
        REG_RAW:                rdata_o = src_word;
        REG_MASKED:             rdata_o = msk_word;
        default:                rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    if (word_hit_i && kind_i == REG_MASKED) begin
      // R6
      masked_subset_chk: assert ((rdata_o & ~src_word) == '0);
    end
  end
endmodule

// File: rtl/grp_irq_combiner.sv
`timescale 1ns/1ps
module grp_irq_combiner
  import grp_irq_pkg::*;
#(
  parameter int NUM_GRP     = 32,
  parameter int GRP_W       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SUMMARY_OFF = 'h100,
  localparam int NUM_SRC      = NUM_GRP * GRP_W,
  localparam int GRP_PER_WORD = DATA_W / GRP_W,
  localparam int NUM_WORDS    = NUM_GRP / GRP_PER_WORD,
  localparam int IDX_W        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_GRP-1:0] irq_o
);
  logic                 word_hit, sum_hit;
  reg_kind_e            kind;
  logic [IDX_W-1:0]     idx;
  logic [NUM_WORDS-1:0] set_sel, clr_sel;
  logic [NUM_SRC-1:0]   en, masked;
  logic [NUM_GRP-1:0]   pend;

  grp_irq_decode #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .SUMMARY_OFF(SUMMARY_OFF)
  ) u_decode (
    .addr_i(addr_i), .we_i(we_i),
    .word_hit_o(word_hit), .sum_hit_o(sum_hit), .kind_o(kind), .idx_o(idx),
    .set_sel_o(set_sel), .clr_sel_o(clr_sel)
  );

  grp_irq_enable_bank #(
    .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)
  ) u_enable (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_sel_i(set_sel), .clr_sel_i(clr_sel), .wdata_i(wdata_i),
    .en_o(en)
  );

  grp_irq_reduce #(
    .NUM_GRP(NUM_GRP), .GRP_W(GRP_W)
  ) u_reduce (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .src_i(src_i), .en_i(en),
    .masked_o(masked), .pend_o(pend), .irq_o(irq_o)
  );

  grp_irq_read_mux #(
    .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .NUM_GRP(NUM_GRP)
  ) u_rmux (
    .word_hit_i(word_hit), .sum_hit_i(sum_hit), .kind_i(kind), .idx_i(idx),
    .en_i(en), .src_i(src_i), .masked_i(masked), .pend_i(pend),
    .rdata_o(rdata_o)
  );

  // R1
  irq_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0));
endmodule

// File: tb/grp_irq_combiner_tb_top.sv
`timescale 1ns/1ps
module grp_irq_combiner_tb_top;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [11:0]   addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [255:0]  src_i = {8{32'hF0F0_00FF}};
  logic [31:0]   irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  grp_irq_combiner dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .src_i(src_i), .irq_o(irq_o)
  );

  // {req[3:0], write, addr[11:0], wdata[31:0], expected read[31:0]}
  localparam int NV = 30;
  localparam logic [80:0] VEC [NV] = '{
    {4'd1,  1'b0, 12'h000, 32'h0,         32'h0},          // R1 enables zero
    {4'd5,  1'b0, 12'h008, 32'h0,         32'hF0F0_00FF},  // R5 raw
    {4'd6,  1'b0, 12'h00C, 32'h0,         32'h0},          // R6 masked none
    {4'd8,  1'b0, 12'h100, 32'h0,         32'h0},          // R8 summary none
    {4'd2,  1'b1, 12'h000, 32'h0000_0101, 32'h0},          // R2 set word0
    {4'd2,  1'b0, 12'h000, 32'h0,         32'h0000_0101},  // R2
    {4'd4,  1'b0, 12'h004, 32'h0,         32'h0000_0101},  // R4 clr offset reads enables
    {4'd6,  1'b0, 12'h00C, 32'h0,         32'h0000_0001},  // R6
    {4'd8,  1'b0, 12'h100, 32'h0,         32'h0000_0001},  // R8
    {4'd2,  1'b1, 12'h070, 32'hFF00_0000, 32'h0},          // R2 set word7
    {4'd6,  1'b0, 12'h07C, 32'h0,         32'hF000_0000},  // R6
    {4'd8,  1'b0, 12'h100, 32'h0,         32'h8000_0001},  // R8
    {4'd3,  1'b1, 12'h004, 32'h0000_0001, 32'h0},          // R3 clear bit0
    {4'd3,  1'b0, 12'h000, 32'h0,         32'h0000_0100},  // R3
    {4'd8,  1'b0, 12'h100, 32'h0,         32'h8000_0000},  // R8
    {4'd10, 1'b1, 12'h008, 32'hFFFF_FFFF, 32'h0},          // R10
    {4'd10, 1'b1, 12'h00C, 32'hFFFF_FFFF, 32'h0},          // R10
    {4'd10, 1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0},          // R10
    {4'd10, 1'b0, 12'h000, 32'h0,         32'h0000_0100},  // R10
    {4'd10, 1'b0, 12'h008, 32'h0,         32'hF0F0_00FF},  // R10
    {4'd9,  1'b1, 12'h0F0, 32'hFFFF_FFFF, 32'h0},          // R9 out of range
    {4'd9,  1'b1, 12'h104, 32'hFFFF_FFFF, 32'h0},          // R9
    {4'd9,  1'b1, 12'h001, 32'hFFFF_FFFF, 32'h0},          // R9 unaligned
    {4'd9,  1'b0, 12'h0F0, 32'h0,         32'h0},          // R9
    {4'd9,  1'b0, 12'h104, 32'h0,         32'h0},          // R9
    {4'd9,  1'b0, 12'h001, 32'h0,         32'h0},          // R9
    {4'd9,  1'b0, 12'h000, 32'h0,         32'h0000_0100},  // R9
    {4'd9,  1'b0, 12'h030, 32'h0,         32'h0},          // R9
    {4'd4,  1'b0, 12'h074, 32'h0,         32'hFF00_0000},  // R4
    {4'd5,  1'b0, 12'h078, 32'h0,         32'hF0F0_00FF}   // R5
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    #2;
    check(req, $sformatf("read %h", a), rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, "irq in reset", irq_o, 32'h0);  // R1
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, "irq after reset", irq_o, 32'h0);  // R1

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) do_write(VEC[i][75:64], VEC[i][63:32]);
      else            do_read(int'(VEC[i][80:77]), VEC[i][75:64], VEC[i][31:0]);
    end

    // R7: group 31 enabled with source pattern 0xF0
    @(negedge clk_i);
    check(7, "irq steady", irq_o, 32'h8000_0000);
    src_i[8] = 1'b1;  // group 1 bit 0, enabled
    #2;
    check(7, "irq before edge", irq_o, 32'h8000_0000);
    @(negedge clk_i);
    check(7, "irq after edge", irq_o, 32'h8000_0002);
    do_read(8, 12'h100, 32'h8000_0002);  // R8
    src_i[8] = 1'b0;
    @(negedge clk_i);
    check(7, "irq falls", irq_o, 32'h8000_0000);

    // R11: group 5 bit 7 = word1 bit 15 = source 47
    do_write(12'h010, 32'h0000_8000);
    src_i[47] = 1'b1;
    @(negedge clk_i);
    check(11, "group5 irq", irq_o, 32'h8000_0020);
    do_read(11, 12'h01C, 32'h0000_8000);
    do_read(11, 12'h100, 32'h8000_0020);

    // R3: clearing group 31 drops its line one edge later
    do_write(12'h074, 32'hFF00_0000);
    check(7, "irq before update", irq_o, 32'h8000_0020);
    @(negedge clk_i);
    check(3, "group31 cleared", irq_o, 32'h0000_0020);

    // R1: reset mid-run with all sources high
    @(negedge clk_i);
    src_i = '1;
    rst_ni = 1'b0;
    #2;
    check(1, "irq async reset", irq_o, 32'h0);
    do_read(1, 12'h010, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check(1, "irq post reset", irq_o, 32'h0);
    do_read(1, 12'h100, 32'h0);

    // R11: group 16 = word4 bit 0
    do_write(12'h040, 32'h0000_0001);
    check(7, "group16 latency", irq_o, 32'h0);
    @(negedge clk_i);
    check(11, "group16 irq", irq_o, 32'h0001_0000);
    do_read(11, 12'h100, 32'h0001_0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule